// File: doc/BRIEF.md
# Vector swizzle index sequencer

This block steps through the element positions of a vectorised swizzle move and emits, one record per cycle at most, a paired step: a source element index or a constant tag, together with the destination element index that receives it. It walks VL subvectors. The source subvector length is an input, and the destination subvector length is decoded from an end marker inside the 12-bit swizzle immediate. The register file and the data path use these records to perform the move. This block produces only the indices.

The immediate holds four 3-bit selectors. The first position occupies bits [2:0], the second [5:3], the third [8:6] and the fourth [11:9]. Each selector has one of these meanings:
- 000: skip the position.
- 001: end marker.
- 010: constant zero.
- 011: constant one.
- 1NN: copy source subelement NN.

The source side and the destination side each walk their own loop nest. Each side uses element-major order by default. A pack flag turns the source loop into subelement-major order, and an unpack flag does the same for the destination loop. The k-th source item always pairs with the k-th destination item.

A start pulse captures the configuration and restarts both walks. In horizontal mode the records stream out until one side runs out, and then a done flag is raised. In vertical-first mode each request pulse allows a bounded number of records, and the walk waits between requests.

Top module: `swz_seq`

## Requirements
- R1: The destination subvector length is one plus the position of the first selector equal to 001. It is 4 if no selector equals 001. This length is the stride of destination indices.
- R2: On the source side, a selector of 000 yields no step, and positions at or after the first 001 marker yield no step. A selector of 010 or 011 yields a constant step: `const_o`=1, `const_one_o` equal to selector bit 0, and `src_idx_o`=0.
- R3: A source selector 1NN at position j of element i yields `src_idx_o` = i*SUBVL + NN, where SUBVL = `subvl_i` (1 to 4).
- R4: On the destination side, a position j below the destination length holding a selector other than 000 or 001 yields `dst_idx_o` = i*dst_len + j. Other positions yield no step.
- R5: The k-th source step is emitted together with the k-th destination step. Emission stops when either side has no more steps.
- R6: With `pack_i` set, the source walk uses subelement-major order: j is the outer loop and i the inner loop. The destination order is unchanged.
- R7: With `unpack_i` set, the destination walk uses subelement-major order. Both flags set together swap both walks.
- R8: In vertical-first mode no record is emitted between start and the first request. Each `req_i` pulse allows at most N further records: N = dst_len when only pack is set, otherwise N = SUBVL.
- R9: In vertical-first mode with both pack and unpack set, each request allows exactly one record.
- R10: After reset `valid_o` and `done_o` are 0. After the last record `done_o` rises and holds with `valid_o` low until the next `start_i`, which clears it and restarts both walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture configuration and restart both walks |
| swiz_i | input | 12 | Swizzle immediate, four 3-bit selectors |
| subvl_i | input | 3 | Source subvector length, 1 to 4 |
| vl_i | input | 7 | Vector length, 1 to 64 |
| pack_i | input | 1 | Source walk in subelement-major order |
| unpack_i | input | 1 | Destination walk in subelement-major order |
| vfirst_i | input | 1 | Vertical-first mode |
| req_i | input | 1 | Vertical-first request pulse |
| valid_o | output | 1 | Record valid this cycle |
| const_o | output | 1 | Record carries a constant instead of a source index |
| const_one_o | output | 1 | Constant value: 1 if set, 0 otherwise |
| src_idx_o | output | 8 | Source element index |
| dst_idx_o | output | 8 | Destination element index |
| done_o | output | 1 | Walk finished, held until next start |

## Verification
The bench builds the block with its default parameters: a 64-entry maximum vector length and 8-bit indices. With these values a full-length run at SUBVL 4 reaches index 255, the top of the index range. Shorter runs cover end markers in different positions, unequal source and destination lengths, and all four loop-order combinations. Vertical-first runs use request budgets that either split or fit the subvector groups.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int unsigned NSEL  = 4;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned LEN_W = $clog2(NSEL);
  localparam int unsigned SW_W  = NSEL * SEL_W;

  localparam logic [SEL_W-1:0] SEL_SKIP = 3'b000;
  localparam logic [SEL_W-1:0] SEL_END  = 3'b001;

  function automatic logic [SEL_W-1:0] sel_at(logic [SW_W-1:0] sw, int unsigned p);
    return sw[p*SEL_W +: SEL_W];
  endfunction

  function automatic logic sel_emits(logic [SEL_W-1:0] s);
    return (s != SEL_SKIP) && (s != SEL_END);
  endfunction
endpackage

// File: rtl/swz_decode.sv
module swz_decode
  import swz_pkg::*;
(
  input  logic [SW_W-1:0]  swiz_i,
  output logic [NSEL-1:0]  src_mask_o,
  output logic [NSEL-1:0]  dst_mask_o,
  output logic [LEN_W-1:0] dst_len_m1_o
);
  logic [NSEL-1:0] end_seen;

  always_comb begin
    logic seen;
    seen = 1'b0;
    dst_len_m1_o = LEN_W'(NSEL - 1);
    for (int j = 0; j < NSEL; j++) begin
      if (!seen && sel_at(swiz_i, j) == SEL_END) dst_len_m1_o = LEN_W'(j);
      seen = seen | (sel_at(swiz_i, j) == SEL_END);
      end_seen[j] = seen;
    end
  end

  // source positions at/after the marker are dead; walk length bounds the rest
  for (genvar g = 0; g < NSEL; g++) begin : g_mask
    assign src_mask_o[g] = sel_emits(sel_at(swiz_i, g)) && !end_seen[g];
    assign dst_mask_o[g] = sel_emits(sel_at(swiz_i, g));
  end
endmodule

// File: rtl/swz_walk.sv
module swz_walk
  import swz_pkg::*;
#(
  parameter int unsigned EW = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [EW-1:0]    vl_m1_i,
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic             outer_i,
  input  logic [NSEL-1:0]  mask_i,
  input  logic             take_i,
  output logic             has_o,
  output logic [EW-1:0]    elem_o,
  output logic [LEN_W-1:0] pos_o,
  output logic             empty_o
);
  logic             run_q, has_q;
  logic [EW-1:0]    ci_q, hi_q;
  logic [LEN_W-1:0] cj_q, hj_q;
  logic             last_i, last_j, load;

  assign last_i = (ci_q == vl_m1_i);
  assign last_j = (cj_q == len_m1_i);
  assign load   = run_q && (!has_q || take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      has_q <= 1'b0;
      ci_q  <= '0;
      cj_q  <= '0;
      hi_q  <= '0;
      hj_q  <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      has_q <= 1'b0;
      ci_q  <= '0;
      cj_q  <= '0;
    end else begin
      if (take_i) has_q <= 1'b0;
      if (load) begin
        if (mask_i[cj_q]) begin
          has_q <= 1'b1;
          hi_q  <= ci_q;
          hj_q  <= cj_q;
        end
        if (!outer_i) begin
          if (last_j) begin
            cj_q <= '0;
            if (last_i) run_q <= 1'b0;
            else        ci_q  <= ci_q + 1'b1;
          end else begin
            cj_q <= cj_q + 1'b1;
          end
        end else begin
          if (last_i) begin
            ci_q <= '0;
            if (last_j) run_q <= 1'b0;
            else        cj_q  <= cj_q + 1'b1;
          end else begin
            ci_q <= ci_q + 1'b1;
          end
        end
      end
    end
  end

  assign has_o   = has_q;
  assign elem_o  = hi_q;
  assign pos_o   = hj_q;
  assign empty_o = !run_q && !has_q;
endmodule

// File: rtl/swz_vf_gate.sv
module swz_vf_gate
  import swz_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           en_i,
  input  logic           active_i,
  input  logic           req_i,
  input  logic [LEN_W:0] runs_i,
  input  logic           fire_i,
  output logic           allow_o
);
  logic [LEN_W:0] budget_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       budget_q <= '0;
    else if (start_i)                  budget_q <= '0;
    else if (req_i && active_i && en_i) budget_q <= runs_i;
    else if (fire_i && budget_q != '0) budget_q <= budget_q - 1'b1;
  end

  assign allow_o = !en_i || (budget_q != '0);
endmodule

// File: rtl/swz_seq.sv
module swz_seq
  import swz_pkg::*;
#(
  parameter int unsigned VL_MAX = 64,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SW_W-1:0]   swiz_i,
  input  logic [LEN_W:0]    subvl_i,
  input  logic [$clog2(VL_MAX):0] vl_i,
  input  logic              pack_i,
  input  logic              unpack_i,
  input  logic              vfirst_i,
  input  logic              req_i,
  output logic              valid_o,
  output logic              const_o,
  output logic              const_one_o,
  output logic [IDX_W-1:0]  src_idx_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic              done_o
);
  localparam int unsigned EW = $clog2(VL_MAX);

  logic [SW_W-1:0]  swiz_q;
  logic [LEN_W-1:0] subvl_m1_q;
  logic [EW-1:0]    vl_m1_q;
  logic             pack_q, unpack_q, vf_q, active_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swiz_q     <= '0;
      subvl_m1_q <= '0;
      vl_m1_q    <= '0;
      pack_q     <= 1'b0;
      unpack_q   <= 1'b0;
      vf_q       <= 1'b0;
    end else if (start_i) begin
      swiz_q     <= swiz_i;
      subvl_m1_q <= LEN_W'(subvl_i - 1'b1);
      vl_m1_q    <= EW'(vl_i - 1'b1);
      pack_q     <= pack_i;
      unpack_q   <= unpack_i;
      vf_q       <= vfirst_i;
    end
  end

  logic [NSEL-1:0]  src_mask, dst_mask;
  logic [LEN_W-1:0] dst_len_m1;

  swz_decode u_dec (
    .swiz_i      (swiz_q),
    .src_mask_o  (src_mask),
    .dst_mask_o  (dst_mask),
    .dst_len_m1_o(dst_len_m1)
  );

  logic             s_has, d_has, s_empty, d_empty, fire, allow;
  logic [EW-1:0]    s_elem, d_elem;
  logic [LEN_W-1:0] s_pos, d_pos;

  swz_walk #(.EW(EW)) u_src (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .vl_m1_i (vl_m1_q),
    .len_m1_i(subvl_m1_q),
    .outer_i (pack_q),
    .mask_i  (src_mask),
    .take_i  (fire),
    .has_o   (s_has),
    .elem_o  (s_elem),
    .pos_o   (s_pos),
    .empty_o (s_empty)
  );

  swz_walk #(.EW(EW)) u_dst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .vl_m1_i (vl_m1_q),
    .len_m1_i(dst_len_m1),
    .outer_i (unpack_q),
    .mask_i  (dst_mask),
    .take_i  (fire),
    .has_o   (d_has),
    .elem_o  (d_elem),
    .pos_o   (d_pos),
    .empty_o (d_empty)
  );

  // vertical-first substep budget per request
  logic [LEN_W:0] runs;
  always_comb begin
    if (pack_q && unpack_q) runs = (LEN_W+1)'(1);
    else if (pack_q)        runs = {1'b0, dst_len_m1} + 1'b1;
    else                    runs = {1'b0, subvl_m1_q} + 1'b1;
  end

  swz_vf_gate u_vf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .en_i    (vf_q),
    .active_i(active_q),
    .req_i   (req_i),
    .runs_i  (runs),
    .fire_i  (fire),
    .allow_o (allow)
  );

  assign fire = active_q && !start_i && s_has && d_has && allow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (active_q && (s_empty || d_empty)) begin
      active_q <= 1'b0;
      done_q   <= 1'b1;
    end
  end

  logic [SEL_W-1:0] s_sel;
  logic [IDX_W-1:0] s_idx, d_idx;
  assign s_sel = sel_at(swiz_q, s_pos);
  assign s_idx = IDX_W'(s_elem) * IDX_W'({1'b0, subvl_m1_q} + 1'b1) + IDX_W'(s_sel[1:0]);
  assign d_idx = IDX_W'(d_elem) * IDX_W'({1'b0, dst_len_m1} + 1'b1) + IDX_W'(d_pos);

  assign valid_o     = fire;
  assign const_o     = !s_sel[2];
  assign const_one_o = !s_sel[2] && s_sel[0];
  assign src_idx_o   = s_sel[2] ? s_idx : '0;
  assign dst_idx_o   = d_idx;
  assign done_o      = done_q;
endmodule

// File: rtl/swz_seq_chk.sv
module swz_seq_chk
  import swz_pkg::*;
#(
  parameter int unsigned EW    = 6,
  parameter int unsigned IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             req_i,
  input logic             valid_o,
  input logic             const_o,
  input logic [IDX_W-1:0] src_idx_o,
  input logic [IDX_W-1:0] dst_idx_o,
  input logic             done_o,
  input logic             vf_q,
  input logic             pack_q,
  input logic             unpack_q,
  input logic [EW-1:0]    vl_m1_q,
  input logic [LEN_W-1:0] subvl_m1_q,
  input logic [LEN_W-1:0] dst_len_m1
);
  logic [2:0] emit_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          emit_cnt <= '0;
    else if (start_i || req_i)            emit_cnt <= '0;
    else if (valid_o && emit_cnt != 3'd7) emit_cnt <= emit_cnt + 1'b1;
  end

  assert_const_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && const_o |-> src_idx_o == '0);

  assert_src_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !const_o |-> int'(src_idx_o) < (int'(vl_m1_q) + 1) * (int'(subvl_m1_q) + 1));

  assert_dst_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> int'(dst_idx_o) < (int'(vl_m1_q) + 1) * (int'(dst_len_m1) + 1));

  assert_vf_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vf_q && valid_o |-> emit_cnt < 3'd4);

  assert_vf_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vf_q && pack_q && unpack_q && valid_o |-> emit_cnt == 3'd0);

  assert_done_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

  assert_done_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  assert_start_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o && !valid_o);
endmodule

bind swz_seq swz_seq_chk #(.EW(EW), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .req_i     (req_i),
  .valid_o   (valid_o),
  .const_o   (const_o),
  .src_idx_o (src_idx_o),
  .dst_idx_o (dst_idx_o),
  .done_o    (done_o),
  .vf_q      (vf_q),
  .pack_q    (pack_q),
  .unpack_q  (unpack_q),
  .vl_m1_q   (vl_m1_q),
  .subvl_m1_q(subvl_m1_q),
  .dst_len_m1(dst_len_m1)
);

// File: tb/sim_swz_seq.sv
module sim_swz_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] swiz_i = '0;
  logic [2:0]  subvl_i = 3'd1;
  logic [6:0]  vl_i = 7'd1;
  logic        pack_i = 1'b0, unpack_i = 1'b0, vfirst_i = 1'b0, req_i = 1'b0;
  logic        valid_o, const_o, const_one_o, done_o;
  logic [7:0]  src_idx_o, dst_idx_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  swz_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .swiz_i(swiz_i),
    .subvl_i(subvl_i), .vl_i(vl_i), .pack_i(pack_i), .unpack_i(unpack_i),
    .vfirst_i(vfirst_i), .req_i(req_i), .valid_o(valid_o), .const_o(const_o),
    .const_one_o(const_one_o), .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o),
    .done_o(done_o)
  );

  typedef struct packed {
    logic       c;
    logic       one;
    logic [7:0] s;
    logic [7:0] d;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  int    got = 0;
  string cur_tag = "R10";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pop expected record and compare
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      item_t a, e;
      a = '{c: const_o, one: const_one_o, s: src_idx_o, d: dst_idx_o};
      got++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected record act=%h exp=none", cur_tag, a);
      end else begin
        e = exp_q.pop_front();
        if (a != e) begin
          errors++;
          $display("FAIL %s record act c=%0d one=%0d s=%0d d=%0d exp c=%0d one=%0d s=%0d d=%0d",
                   cur_tag, a.c, a.one, a.s, a.d, e.c, e.one, e.s, e.d);
        end
      end
    end
  end

  function automatic logic [11:0] sw4(logic [2:0] x, logic [2:0] y, logic [2:0] z, logic [2:0] w);
    return {w, z, y, x};
  endfunction

  task automatic wait_done(string tag);
    int k;
    k = 0;
    while (!done_o && k < 4000) begin
      @(negedge clk_i);
      k++;
    end
    chk(done_o == 1'b1, tag, "done_o after run (R10)", done_o, 1);
    chk(valid_o == 1'b0, tag, "valid_o while done (R10)", valid_o, 0);
    chk(exp_q.size() == 0, tag, "records left undelivered (R5)", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic run_case(string tag, logic [11:0] sw, int sv, int vl, bit pk, bit up, bit vf);
    int    m, dl, n, runs, remaining, k, target, w;
    int    ss[$];
    bit    sc[$];
    bit    so[$];
    int    dd[$];
    logic [2:0] sel;
    m = 4;
    for (int j = 3; j >= 0; j--) if (sw[3*j +: 3] == 3'b001) m = j;
    dl = (m == 4) ? 4 : m + 1;
    // source list
    for (int a = 0; a < (pk ? sv : vl); a++)
      for (int b = 0; b < (pk ? vl : sv); b++) begin
        int i, j;
        i = pk ? b : a;
        j = pk ? a : b;
        sel = sw[3*j +: 3];
        if (j < m && sel != 3'b000) begin
          sc.push_back(!sel[2]);
          so.push_back(!sel[2] && sel[0]);
          ss.push_back(sel[2] ? i*sv + int'(sel[1:0]) : 0);
        end
      end
    // destination list
    for (int a = 0; a < (up ? dl : vl); a++)
      for (int b = 0; b < (up ? vl : dl); b++) begin
        int i, j;
        i = up ? b : a;
        j = up ? a : b;
        sel = sw[3*j +: 3];
        if (sel != 3'b000 && sel != 3'b001) dd.push_back(i*dl + j);
      end
    n = (ss.size() < dd.size()) ? ss.size() : dd.size();
    for (int q = 0; q < n; q++)
      exp_q.push_back('{c: sc[q], one: so[q], s: 8'(ss[q]), d: 8'(dd[q])});
    cur_tag = tag;
    @(posedge clk_i); #1;
    swiz_i = sw; subvl_i = 3'(sv); vl_i = 7'(vl);
    pack_i = pk; unpack_i = up; vfirst_i = vf; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    if (vf) begin
      runs = (pk && up) ? 1 : (pk ? dl : sv);
      repeat (6) @(negedge clk_i);
      chk(got == 0 || exp_q.size() == n, tag, "records before first request (R8)", n - exp_q.size(), 0);
      remaining = n;
      while (remaining > 0) begin
        k = (remaining < runs) ? remaining : runs;
        target = got + k;
        @(posedge clk_i); #1 req_i = 1'b1;
        @(posedge clk_i); #1 req_i = 1'b0;
        w = 0;
        while (got != target && w < 3000) begin
          @(negedge clk_i);
          w++;
        end
        repeat (6) @(negedge clk_i);
        chk(got == target, tag, "records for one request", got, target);
        remaining -= k;
      end
    end
    wait_done(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired in %s", cur_tag);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R10", "valid_o after reset", valid_o, 0);
    chk(done_o == 1'b0, "R10", "done_o after reset", done_o, 0);

    // R1: no marker, full 4-wide identity
    run_case("R1 nomark", sw4(3'b100, 3'b101, 3'b110, 3'b111), 4, 3, 0, 0, 0);
    // R1: marker in third slot, dst length 3
    run_case("R1 mark", sw4(3'b110, 3'b101, 3'b001, 3'b000), 3, 3, 0, 0, 0);
    // R2: constants mixed with indices
    run_case("R2 const", sw4(3'b100, 3'b011, 3'b010, 3'b111), 4, 2, 0, 0, 0);
    // R2/R4 skip positions: W.Y.
    run_case("R2 skip", sw4(3'b111, 3'b000, 3'b101, 3'b000), 4, 2, 0, 0, 0);
    // R3: source length 2 into a 4-wide destination
    run_case("R3 subvl2", sw4(3'b101, 3'b101, 3'b100, 3'b100), 2, 3, 0, 0, 0);
    // R3: full vector, reaches index 255
    run_case("R3 vl64", sw4(3'b100, 3'b101, 3'b110, 3'b111), 4, 64, 0, 0, 0);
    // R4: marker first, no destination steps
    run_case("R4 mark0", sw4(3'b001, 3'b100, 3'b101, 3'b110), 4, 3, 0, 0, 0);
    // R5: source shorter than destination
    run_case("R5 short", sw4(3'b100, 3'b100, 3'b100, 3'b100), 1, 4, 0, 0, 0);
    // R6: pack
    run_case("R6 pack", sw4(3'b100, 3'b101, 3'b010, 3'b111), 4, 3, 1, 0, 0);
    // R7: unpack, then both
    run_case("R7 unpack", sw4(3'b100, 3'b000, 3'b110, 3'b001), 2, 3, 0, 1, 0);
    run_case("R7 both", sw4(3'b111, 3'b110, 3'b101, 3'b100), 4, 3, 1, 1, 0);
    // R8: vertical-first normal, pack-only, unpack-only
    run_case("R8 vf", sw4(3'b100, 3'b101, 3'b110, 3'b111), 3, 3, 0, 0, 1);
    run_case("R8 vfpack", sw4(3'b100, 3'b101, 3'b001, 3'b000), 4, 3, 1, 0, 1);
    run_case("R8 vfunpack", sw4(3'b101, 3'b100, 3'b011, 3'b000), 2, 3, 0, 1, 1);
    // R9: both flags in vertical-first mode
    run_case("R9 vfboth", sw4(3'b100, 3'b101, 3'b110, 3'b111), 4, 2, 1, 1, 1);
    // R10: nothing to emit, done still raised
    run_case("R10 allskip", 12'h000, 4, 5, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule